// File: doc/BRIEF.md
# Serial SRAM Slave Front End

This block is the device side of a byte-wide serial static RAM. A host selects it with an active-low select, then clocks in an instruction byte, a three-byte address and write data, or clocks read data back out. The serial link runs over one, two or four lanes. The width is changed by instructions and stays in force across selections. All pins are sampled by a fast system clock, so the serial clock is an ordinary data input that is edge-detected internally. Incoming bits are taken on serial-clock rising edges. Outgoing bits change only after serial-clock falling edges.

Reads and writes follow an access mode held in an internal mode byte. Byte mode moves a single byte. Page mode keeps the address inside its 32-byte page. Sequential mode walks the whole array and wraps from the top back to zero. A read inserts a dummy gap of one byte-time before the first data bit: 8 serial clocks on one lane, 4 on two lanes, 2 on four lanes. A pause input freezes a transfer mid-sequence. The pause only takes hold while the serial clock is low. The array is a small register file behind a synchronous read/write port. Its depth is set by a parameter.

There are no parallel data streams at this block's edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or serial-data signal.

Top module: `ssram_slave`

## Requirements
- R1: While `cs_n` is high, `sio_oe` is 0 and `standby` is 1, one system clock after the synchronised select is seen high.
- R2: After reset, no command is accepted until `cs_n` has been seen high. A selection that is already low when reset ends is ignored in full, and the array is unchanged by it.
- R3: Instruction, address and write data are taken on serial-clock rising edges. Read data on `sio_out` changes only after falling edges and is stable across each rising edge.
- R4: A read (opcode 0x03) has one byte-time of dummy clocks after the last address bit: 8, 4 or 2 serial clocks for one, two or four lanes. `sio_oe` stays 0 during the dummy clocks, and the first data bit is driven after the falling edge that follows the last dummy rising edge.
- R5: Opcodes are: 0x02 write, 0x03 read, 0x01 write the mode byte (one data byte follows), 0x05 read the mode byte (it is returned at once, with no dummy clocks), 0x3B select two lanes, 0x38 select four lanes, 0xFF return to one lane. Any other opcode is ignored until deselect.
- R6: Mode byte bits [7:6] select the access mode: 00 is byte, 10 is page, 01 or 11 is sequential. The mode byte resets to 0x40 and reads back as written.
- R7: In page mode, a burst address increments modulo 32 and keeps its upper bits, for both reads and writes.
- R8: In sequential mode, a burst address increments through the array and wraps from the last byte to address 0.
- R9: In byte mode, a read returns one byte and then releases `sio_oe`. A write stores only its first data byte.
- R10: With `hold_n` low, serial-clock edges are ignored and the transfer resumes where it stopped once `hold_n` is high. If `hold_n` falls while the serial clock is high, the pause begins at the next serial-clock low.
- R11: Raising `cs_n` at any point aborts the command. A partly shifted write byte is discarded.
- R12: The address is 24 bits sent most significant byte first, and only its low `ADDR_W` bits select a byte. Higher bits are ignored.
- R13: Lane usage: one lane receives on `sio_in[0]` and drives `sio_out[1]` (`sio_oe`=0010). Two lanes use bits [1:0] (`sio_oe`=0011). Four lanes use [3:0] (`sio_oe`=1111). Every lane group carries the most significant bits first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low device select |
| hold_n | input | 1 | Active-low transfer pause |
| sio_in | input | 4 | Serial data lanes into the device |
| sio_out | output | 4 | Serial data lanes out of the device |
| sio_oe | output | 4 | Per-lane output enable (0 means high impedance) |
| standby | output | 1 | High while the device is deselected |

## Verification
The hardest situation to reach is a pause that is requested while the serial clock is high and released in the middle of a byte. The falling edge that follows must still be honoured, every later toggle must be ignored, and the shifted bits must stay exactly where they were. The bench drives the serial clock by hand bit by bit. It drops `hold_n` between a rising and a falling edge inside a write-data byte, and separately during a low phase inside the address. It then toggles the clock with all-ones garbage on the lanes before resuming. The data read back shows whether any garbage edge leaked into the shift state.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2} lane_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_RDATA, ST_WDATA, ST_MWR, ST_SINK
  } state_t;
  typedef enum logic [1:0] {ACC_BYTE, ACC_PAGE, ACC_SEQ} acc_t;

  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_MODE_WR = 8'h01;
  localparam logic [7:0] OP_MODE_RD = 8'h05;
  localparam logic [7:0] OP_TO_X2   = 8'h3B;
  localparam logic [7:0] OP_TO_X4   = 8'h38;
  localparam logic [7:0] OP_TO_X1   = 8'hFF;
  localparam logic [7:0] MODE_RESET = 8'h40;
  localparam int PAGE_BITS  = 5;
  localparam int ADDR_BYTES = 3;

  function automatic logic [4:0] lane_beats(lane_t l);
    case (l)
      LANE_X2: return 5'd4;
      LANE_X4: return 5'd2;
      default: return 5'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(lane_t l);
    case (l)
      LANE_X2: return 4'b0011;
      LANE_X4: return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction
endpackage

// File: rtl/ssram_pinsync.sv
module ssram_pinsync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       hold_n,
  input  logic [3:0] sio_in,
  output logic       rise,
  output logic       fall,
  output logic       sel_hi,
  output logic       held,
  output logic [3:0] sio_q
);
  logic sck_q, sck_qq, cs_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_qq <= 1'b0;
      cs_q   <= 1'b0;
      hold_q <= 1'b1;
      sio_q  <= 4'h0;
      held   <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_qq <= sck_q;
      cs_q   <= cs_n;
      hold_q <= hold_n;
      sio_q  <= sio_in;
      // pause engages only once the serial clock is seen low
      held   <= !cs_q && !hold_q && (!sck_q || held);
    end
  end

  assign sel_hi = cs_q;
  assign rise   = sck_q && !sck_qq && !held && !cs_q;
  assign fall   = !sck_q && sck_qq && !held && !cs_q;
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/ssram_slave.sv
module ssram_slave
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       hold_n,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe,
  output logic       standby
);
  localparam int SH_W = 8 * ADDR_BYTES;

  logic rise, fall, sel_hi, held;
  logic [3:0] sio_q;
  state_t state;
  lane_t  lane;
  acc_t   acc;
  logic [4:0] beat, bpb, limit;
  logic last;
  logic [SH_W-1:0] sh, sh_nxt;
  logic [ADDR_W-1:0] addr, addr_inc, waddr;
  logic [7:0] mode_reg, oshr, rdata, wdata;
  logic drv, oneshot, armed, we, is_rd;

  ssram_pinsync u_pins (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .sio_in(sio_in), .rise(rise), .fall(fall), .sel_hi(sel_hi),
    .held(held), .sio_q(sio_q)
  );

  ssram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(addr), .rdata(rdata)
  );

  always_comb begin
    case (lane)
      LANE_X2: sh_nxt = {sh[SH_W-3:0], sio_q[1:0]};
      LANE_X4: sh_nxt = {sh[SH_W-5:0], sio_q[3:0]};
      default: sh_nxt = {sh[SH_W-2:0], sio_q[0]};
    endcase
    bpb   = lane_beats(lane);
    limit = (state == ST_ADDR) ? 5'(bpb * 5'd3) : bpb;
    last  = (beat == limit - 5'd1);
    case (mode_reg[7:6])
      2'b00:   acc = ACC_BYTE;
      2'b10:   acc = ACC_PAGE;
      default: acc = ACC_SEQ;
    endcase
    if (acc == ACC_PAGE)
      addr_inc = {addr[ADDR_W-1:PAGE_BITS], addr[PAGE_BITS-1:0] + 1'b1};
    else
      addr_inc = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  lane <= LANE_X1;  beat <= '0;  sh <= '0;
      addr <= '0;  mode_reg <= MODE_RESET;  oshr <= '0;  drv <= 1'b0;
      oneshot <= 1'b0;  armed <= 1'b0;  we <= 1'b0;  waddr <= '0;
      wdata <= '0;  sio_out <= '0;  is_rd <= 1'b0;
    end else begin
      we <= 1'b0;
      if (sel_hi) begin
        armed <= 1'b1;
        state <= ST_IDLE;
        beat  <= '0;
        drv   <= 1'b0;
      end else if (state == ST_IDLE) begin
        if (armed) begin
          state <= ST_CMD;
          beat  <= '0;
        end
      end else if (rise) begin
        sh   <= sh_nxt;
        beat <= last ? 5'd0 : beat + 5'd1;
        if (last) begin
          case (state)
            ST_CMD: begin
              case (sh_nxt[7:0])
                OP_READ:    begin is_rd <= 1'b1; state <= ST_ADDR; end
                OP_WRITE:   begin is_rd <= 1'b0; state <= ST_ADDR; end
                OP_MODE_WR: state <= ST_MWR;
                OP_MODE_RD: begin oshr <= mode_reg; oneshot <= 1'b1; state <= ST_RDATA; end
                OP_TO_X2:   begin lane <= LANE_X2; state <= ST_SINK; end
                OP_TO_X4:   begin lane <= LANE_X4; state <= ST_SINK; end
                OP_TO_X1:   begin lane <= LANE_X1; state <= ST_SINK; end
                default:    state <= ST_SINK;
              endcase
            end
            ST_ADDR: begin
              addr  <= sh_nxt[ADDR_W-1:0];
              state <= is_rd ? ST_DUMMY : ST_WDATA;
            end
            ST_DUMMY: begin
              oshr    <= rdata;
              addr    <= addr_inc;
              oneshot <= (acc == ACC_BYTE);
              state   <= ST_RDATA;
            end
            ST_RDATA: begin
              if (oneshot) begin
                state <= ST_SINK;
                drv   <= 1'b0;
              end else begin
                oshr <= rdata;
                addr <= addr_inc;
              end
            end
            ST_WDATA: begin
              we    <= 1'b1;
              waddr <= addr;
              wdata <= sh_nxt[7:0];
              addr  <= addr_inc;
              if (acc == ACC_BYTE) state <= ST_SINK;
            end
            ST_MWR: begin
              mode_reg <= sh_nxt[7:0];
              state    <= ST_SINK;
            end
            default: ;
          endcase
        end
      end else if (fall && state == ST_RDATA) begin
        drv <= 1'b1;
        case (lane)
          LANE_X2: begin sio_out <= {2'b00, oshr[7:6]}; oshr <= {oshr[5:0], 2'b00}; end
          LANE_X4: begin sio_out <= oshr[7:4];          oshr <= {oshr[3:0], 4'h0}; end
          default: begin sio_out <= {2'b00, oshr[7], 1'b0}; oshr <= {oshr[6:0], 1'b0}; end
        endcase
      end
    end
  end

  assign sio_oe  = drv ? lane_mask(lane) : 4'b0000;
  assign standby = sel_hi;

  assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hi |=> (sio_oe == 4'b0000));
  assert_wait_for_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (state == ST_IDLE));
  assert_pause_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !sel_hi) |=> ($stable(beat) && $stable(sh)));
  assert_page_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_PAGE && (state == ST_RDATA || state == ST_WDATA))
      |=> $stable(addr[ADDR_W-1:PAGE_BITS]));
  assert_abort_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hi |=> (state == ST_IDLE && !we));
  assert_lane_enables_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});
endmodule

// File: tb/sim_ssram_slave.sv
module sim_ssram_slave;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [3:0] sio_in = 4'h0;
  logic [3:0] sio_out, sio_oe;
  logic standby;

  always #10 clk = ~clk;

  ssram_slave #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe), .standby(standby)
  );

  int checks = 0, fails = 0, lane = 0, acc = 2;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] oe_mask();
    return (lane == 0) ? 4'b0010 : (lane == 1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic beat(input logic [3:0] din, output logic [3:0] d, output logic [3:0] o,
                      output logic [3:0] p);
    sio_in = din; tick(4); d = sio_out; o = sio_oe;
    sck = 1'b1; tick(3); p = sio_out; tick(1); sck = 1'b0;
  endtask

  task automatic send_part(input logic [7:0] b, input int k0, input int k1);
    logic [3:0] d, o, p;
    int w;
    w = 1 << lane;
    for (int k = k0; k < k1; k++) begin
      logic [7:0] ch;
      ch = 8'((int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1));
      beat(ch[3:0], d, o, p);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_part(b, 0, 8 >> lane);
  endtask

  task automatic send_addr(input int a);
    send_byte(8'(a >> 16)); send_byte(8'(a >> 8)); send_byte(8'(a));
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit oe_ok, output bit oe_any,
                           output bit stable_ok);
    logic [3:0] d, o, p, ch;
    int w;
    w = 1 << lane;
    b = 8'h00; oe_ok = 1'b1; oe_any = 1'b0; stable_ok = 1'b1;
    for (int k = 0; k < (8 >> lane); k++) begin
      beat(4'h0, d, o, p);
      ch = (lane == 0) ? {3'b000, d[1]} : (lane == 1) ? {2'b00, d[1:0]} : d;
      b = 8'((int'(b) << w) | int'(ch));
      if (o != oe_mask()) oe_ok = 1'b0;
      if (o != 4'h0) oe_any = 1'b1;
      if (p != d) stable_ok = 1'b0;
    end
  endtask

  task automatic select();
    cs_n = 1'b0; tick(4);
  endtask

  task automatic deselect();
    tick(2); cs_n = 1'b1; tick(6);
  endtask

  function automatic int nxt(input int a);
    if (acc == 1) return (a & ~31) | ((a + 1) & 31);
    return (a + 1) % DEPTH;
  endfunction

  task automatic do_write(input int a, input int n, input int v);
    int m;
    select(); send_byte(8'h02); send_addr(a);
    m = a % DEPTH;
    for (int i = 0; i < n; i++) begin
      send_byte(8'(v + i));
      if (acc != 0 || i == 0) model[m] = 8'(v + i);
      m = nxt(m);
    end
    deselect();
  endtask

  task automatic do_read(input int a, input int n, input string req);
    logic [3:0] d, o, p;
    logic [7:0] b;
    bit oe_ok, oe_any, st, dummy_ok;
    int m;
    select(); send_byte(8'h03); send_addr(a);
    dummy_ok = 1'b1;
    for (int k = 0; k < (8 >> lane); k++) begin
      beat(4'h0, d, o, p);
      if (o != 4'h0) dummy_ok = 1'b0;
    end
    check(dummy_ok, "R4 dummy clocks keep lanes released", int'(o), 0);
    m = a % DEPTH;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, oe_ok, oe_any, st);
      if (acc == 0 && i > 0) begin
        check(!oe_any, "R9 byte mode releases lanes", int'(oe_any), 0);
      end else begin
        check(b == model[m], req, int'(b), int'(model[m]));
        check(oe_ok, "R13 lane enables during data", int'(sio_oe), int'(oe_mask()));
        check(st, "R3 data stable across rising edge", 0, 1);
      end
      m = nxt(m);
    end
    deselect();
  endtask

  task automatic set_mode(input logic [7:0] v);
    select(); send_byte(8'h01); send_byte(v); deselect();
  endtask

  task automatic read_mode(output logic [7:0] v);
    bit a1, a2, a3;
    select(); send_byte(8'h05); recv_byte(v, a1, a2, a3); deselect();
  endtask

  task automatic lane_cmd(input logic [7:0] op, input int nl);
    select(); send_byte(op); deselect(); lane = nl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-to-end run actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] mv;
    logic [7:0] enc [3];
    int a;
    enc[0] = 8'h00; enc[1] = 8'h80; enc[2] = 8'h40;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

    // r2_: select held low across reset release must be ignored
    tick(5); rst_n = 1'b1; tick(4);
    send_byte(8'h02); send_addr(0); send_byte(8'hAA);
    deselect();
    check(sio_oe == 4'h0 && standby == 1'b1, "R1 deselected state", int'(sio_oe), 0);
    read_mode(mv);
    check(mv == 8'h40, "R6 mode byte reset value", int'(mv), 8'h40);
    do_read(0, 1, "R2 write before arming ignored");

    for (int l = 0; l < 3; l++) begin
      if (l == 1) lane_cmd(8'h3B, 1);
      if (l == 2) lane_cmd(8'h38, 2);
      for (int ac = 0; ac < 3; ac++) begin
        acc = ac;
        set_mode(enc[ac]);
        read_mode(mv);
        check(mv == enc[ac], "R5 R6 mode byte write and readback", int'(mv), int'(enc[ac]));
        a = (l * 3 + ac) * 32 + 28;
        do_write(a, 7, l * 40 + ac * 9 + 17);
        do_read(a + ((l + 1) << 16), 7,
                (ac == 1) ? "R7 page wrap" : (ac == 0) ? "R9 byte mode" : "R12 aliased address");
      end
    end
    lane_cmd(8'hFF, 0);
    acc = 2; set_mode(8'h40);
    read_mode(mv);
    check(mv == 8'h40, "R13 back to one lane", int'(mv), 8'h40);

    do_write(DEPTH - 3, 5, 8'hC0);
    do_read(DEPTH - 3, 5, "R8 sequential wrap to zero");

    // R11: partial second byte is discarded on deselect
    select(); send_byte(8'h02); send_addr(300);
    send_byte(8'h5A); send_part(8'hC3, 0, 4);
    deselect();
    model[300] = 8'h5A;
    do_read(300, 2, "R11 abort discards partial byte");

    // R10: pause during address (clock low) and during data (clock high)
    select(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h01);
    send_part(8'h90, 0, 3);
    hold_n = 1'b0; tick(3);
    repeat (3) begin sio_in = 4'hF; sck = 1'b1; tick(3); sck = 1'b0; tick(3); end
    hold_n = 1'b1; tick(3);
    send_part(8'h90, 3, 8);
    send_part(8'h6E, 0, 5);
    sio_in = 4'h1;              // bit 2 of 0x6E
    tick(4); sck = 1'b1; tick(2); hold_n = 1'b0; tick(4); sck = 1'b0; tick(4);
    repeat (3) begin sio_in = 4'hF; sck = 1'b1; tick(3); sck = 1'b0; tick(3); end
    hold_n = 1'b1; tick(4);
    send_part(8'h6E, 6, 8);
    deselect();
    model[400] = 8'h6E;
    do_read(400, 1, "R10 pause keeps shift state");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule